// File: doc/BRIEF.md
# DDR2 Extended Mode Register (1) Writer

This block sits in a DDR2 memory controller. It builds the command that loads extended mode register (1) and places that command on the memory command bus. The register controls the following settings:

- DLL on or off
- output drive strength
- additive latency
- on-die termination setting
- off-chip driver calibration control
- data strobe disable
- read data strobe enable

The register content is undefined after power-up. The controller must therefore request at least one write before normal traffic begins.

A write request is held until two conditions are true: all banks report precharged, and the clock enable is high. The block then drives the write for one cycle. It keeps the bus at NOP for a programmable settling window, and marks the end of that window with a one-cycle completion pulse. A request that arrives during a write or its window is remembered and served afterwards.

The block also owns a read-permitted flag. This flag stays low for a fixed number of cycles after each write that turns the DLL on, and after each self-refresh exit. It also stays low while the DLL is off or the memory is in self-refresh.

Top module: `ddr2_emr1_writer`

## Requirements
- R1: Outside a register write, the bus carries NOP: chip select low, row strobe, column strobe and write enable high, bank address 0, address 0. A register write drives all four command lines low and bank address 2'b01 for exactly one cycle.
- R2: The write address is formed as follows. Bit 0 = DLL disable (0 turns the DLL on). Bit 1 = half drive. Bit 2 = termination setting bit 0. Bits 5:3 = additive latency. Bit 6 = termination setting bit 1. Bits 9:7 = calibration control. Bit 10 = strobe disable. Bit 11 = read strobe enable. Bits 15:12 = zero. All fields are sampled on the edge that issues the write.
- R3: A pending request issues only on an edge where both all-banks-precharged and clock-enable are high. Otherwise the request waits and the bus stays at NOP.
- R4: After a write cycle, the next TMRD cycles carry NOP. The completion pulse is high only in the TMRD-th cycle after the write, for one cycle.
- R5: A request received during a write or its settling window is kept. It issues in cycle TMRD+1 after the earlier write, using the field values present at that issue.
- R6: After reset, read-permitted is low. After a write with the DLL on, read-permitted rises exactly LOCK_CYC clock edges after the issuing edge.
- R7: A write with the DLL off forces read-permitted low, and it stays low until a later DLL-on write completes its lockout.
- R8: A self-refresh entry event drops read-permitted. An exit event restarts the lockout, so read-permitted rises exactly LOCK_CYC edges after the edge that samples the exit.
- R9: While reset is active, the outputs show NOP, no completion pulse, and no read permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dll_disable | input | 1 | 1 turns the DLL off |
| cfg_half_drive | input | 1 | Select half output drive |
| cfg_add_lat | input | 3 | Additive latency code |
| cfg_odt | input | 2 | Termination setting |
| cfg_ocd | input | 3 | Driver calibration control |
| cfg_dqs_off | input | 1 | Disable data strobe |
| cfg_rdqs_on | input | 1 | Enable read data strobe |
| prog_req | input | 1 | Request one register write |
| all_banks_idle | input | 1 | All banks precharged |
| cke_high | input | 1 | Clock enable currently high |
| sr_enter | input | 1 | Self-refresh entry event |
| sr_exit | input | 1 | Self-refresh exit event |
| mem_cs_n | output | 1 | Chip select |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | 16 | Address bus |
| prog_done | output | 1 | Completion pulse at end of settling window |
| read_ok | output | 1 | Read commands permitted |

## Verification
All 4096 combinations of the twelve configuration bits are written back to back. Every write is checked against a bit-weighted sum computed in the bench, which separates any swapped, shifted or dropped field. Separate patterns cover the following cases:
- a request made while the banks are busy, and one made while the clock enable is low, which separates gating from immediate issue
- a request made during the settling window, which shows whether the request is held or dropped
- DLL-on writes, DLL-off writes and self-refresh events, each probed one cycle before and at the end of the lockout, which catches an off-by-one in the lockout count

// File: rtl/ddr2_emr1_writer.sv
module ddr2_emr1_writer #(
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dll_disable,
  input  logic        cfg_half_drive,
  input  logic [2:0]  cfg_add_lat,
  input  logic [1:0]  cfg_odt,
  input  logic [2:0]  cfg_ocd,
  input  logic        cfg_dqs_off,
  input  logic        cfg_rdqs_on,
  input  logic        prog_req,
  input  logic        all_banks_idle,
  input  logic        cke_high,
  input  logic        sr_enter,
  input  logic        sr_exit,
  output logic        mem_cs_n,
  output logic        mem_ras_n,
  output logic        mem_cas_n,
  output logic        mem_we_n,
  output logic [1:0]  mem_ba,
  output logic [15:0] mem_addr,
  output logic        prog_done,
  output logic        read_ok
);
  localparam int MW = $clog2(TMRD + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic          pend, wr_q, done_q, dll_on, in_sr;
  logic [MW-1:0] mrd_cnt;
  logic [LW-1:0] lock_cnt;
  logic [15:0]   addr_q;

  wire want  = pend | prog_req;
  wire busy  = mrd_cnt != '0;
  wire issue = want & ~busy & all_banks_idle & cke_high;
  wire [15:0] word = {4'b0000, cfg_rdqs_on, cfg_dqs_off, cfg_ocd,
                      cfg_odt[1], cfg_add_lat, cfg_odt[0], cfg_half_drive,
                      cfg_dll_disable};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      mrd_cnt <= '0;
      addr_q  <= '0;
    end else begin
      pend   <= want & ~issue;
      wr_q   <= issue;
      done_q <= (mrd_cnt == MW'(1));
      if (issue) begin
        mrd_cnt <= MW'(TMRD);
        addr_q  <= word;
      end else if (busy) begin
        mrd_cnt <= mrd_cnt - MW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dll_on   <= 1'b0;
      in_sr    <= 1'b0;
      lock_cnt <= '0;
    end else begin
      if (issue) dll_on <= ~cfg_dll_disable;
      if (sr_enter) in_sr <= 1'b1;
      else if (sr_exit) in_sr <= 1'b0;
      if ((issue && !cfg_dll_disable) || sr_exit) lock_cnt <= LW'(LOCK_CYC);
      else if (lock_cnt != '0) lock_cnt <= lock_cnt - LW'(1);
    end
  end

  assign mem_cs_n  = 1'b0;
  assign mem_ras_n = ~wr_q;
  assign mem_cas_n = ~wr_q;
  assign mem_we_n  = ~wr_q;
  assign mem_ba    = wr_q ? 2'b01 : 2'b00;
  assign mem_addr  = wr_q ? addr_q : 16'h0000;
  assign prog_done = done_q;
  assign read_ok   = dll_on & ~in_sr & (lock_cnt == '0);
endmodule

// File: rtl/ddr2_emr1_writer_chk.sv
module ddr2_emr1_writer_chk #(
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        all_banks_idle,
  input logic        cke_high,
  input logic        sr_exit,
  input logic        mem_cs_n,
  input logic        mem_ras_n,
  input logic        mem_cas_n,
  input logic        mem_we_n,
  input logic [1:0]  mem_ba,
  input logic [15:0] mem_addr,
  input logic        prog_done,
  input logic        read_ok
);
  localparam int GW = $clog2(TMRD + 2) + 1;
  localparam int SW = $clog2(LOCK_CYC + 2) + 1;

  wire wr  = !mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n;
  wire nop = !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n;

  logic [GW-1:0] gap;
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= GW'(TMRD + 1);
      since <= '0;
    end else begin
      if (wr) gap <= GW'(1);
      else if (gap < GW'(TMRD + 1)) gap <= gap + GW'(1);
      if (sr_exit) since <= '0;
      else if (wr && !mem_addr[0]) since <= SW'(1);
      else if (since < SW'(LOCK_CYC + 1)) since <= since + SW'(1);
    end
  end

  // R1
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr || (nop && mem_ba == 2'b00 && mem_addr == 16'h0));
  // R1
  wr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (mem_ba == 2'b01 && mem_addr[15:12] == 4'h0));
  // R3
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(all_banks_idle && cke_high));
  // R4
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> gap > GW'(TMRD));
  // R4
  done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> gap == GW'(TMRD));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_done);
  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> since >= SW'(LOCK_CYC));
  // R8
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !read_ok);
endmodule

bind ddr2_emr1_writer ddr2_emr1_writer_chk #(.TMRD(TMRD), .LOCK_CYC(LOCK_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .all_banks_idle(all_banks_idle), .cke_high(cke_high),
  .sr_exit(sr_exit), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr), .prog_done(prog_done),
  .read_ok(read_ok));

// File: tb/ddr2_emr1_writer_tb_top.sv
module ddr2_emr1_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMRD = 2;
  localparam int LOCK_CYC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dll_dis = 0, half = 0, dqs_off = 0, rdqs_on = 0;
  logic [2:0] al = 0, ocd = 0;
  logic [1:0] odt = 0;
  logic req = 0, idle = 1, cke = 1, sre = 0, srx = 0;
  logic cs_n, ras_n, cas_n, we_n, done, rok;
  logic [1:0] ba;
  logic [15:0] addr;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_emr1_writer #(.TMRD(TMRD), .LOCK_CYC(LOCK_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dll_disable(dll_dis), .cfg_half_drive(half),
    .cfg_add_lat(al), .cfg_odt(odt), .cfg_ocd(ocd), .cfg_dqs_off(dqs_off),
    .cfg_rdqs_on(rdqs_on), .prog_req(req), .all_banks_idle(idle), .cke_high(cke),
    .sr_enter(sre), .sr_exit(srx), .mem_cs_n(cs_n), .mem_ras_n(ras_n),
    .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr),
    .prog_done(done), .read_ok(rok));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bus();
    return {8'h0, cs_n, ras_n, cas_n, we_n, 2'b00, ba, addr};
  endfunction

  localparam logic [31:0] NOPV = {8'h0, 4'b0111, 2'b00, 2'b00, 16'h0};

  function automatic logic [31:0] wrv(input logic [15:0] a);
    return {8'h0, 4'b0000, 2'b00, 2'b01, a};
  endfunction

  function automatic logic [15:0] expect_addr();
    return 16'(dll_dis) + 16'(half) * 2 + 16'(odt[0]) * 4 + 16'(al) * 8 +
           16'(odt[1]) * 64 + 16'(ocd) * 128 + 16'(dqs_off) * 1024 + 16'(rdqs_on) * 2048;
  endfunction

  task automatic set_cfg(input logic [11:0] c);
    {rdqs_on, dqs_off, ocd, odt, al, half, dll_dis} = c;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] ea;
    repeat (3) tick();
    // R9 reset state
    check(bus() == NOPV, "R9 bus", bus(), NOPV);
    check(done == 0 && rok == 0, "R9 flags", {done, rok}, 0);
    rst_n = 1;
    tick();
    check(rok == 0, "R6 no read before first write", rok, 0);

    // R2 sweep of every configuration, R4 window and pulse
    for (int c = 0; c < 4096; c++) begin
      set_cfg(12'(c));
      ea = expect_addr();
      req = 1;
      tick();
      req = 0;
      check(bus() == wrv(ea), "R2 address", bus(), wrv(ea));
      check(done == 0, "R4 done early", done, 0);
      for (int k = 1; k <= TMRD; k++) begin
        tick();
        check(bus() == NOPV, "R4 nop in window", bus(), NOPV);
        check(done == (k == TMRD), "R4 done pulse", done, (k == TMRD));
      end
    end
    tick();
    check(done == 0, "R4 single pulse", done, 0);

    // R3 banks not precharged
    idle = 0; set_cfg(12'h0A5); ea = expect_addr();
    req = 1; tick(); req = 0;
    for (int k = 0; k < 5; k++) begin
      check(bus() == NOPV, "R3 wait banks", bus(), NOPV);
      tick();
    end
    idle = 1; tick();
    check(bus() == wrv(ea), "R3 issue after banks idle", bus(), wrv(ea));
    repeat (TMRD) tick();

    // R3 clock enable low
    cke = 0; set_cfg(12'h35A); ea = expect_addr();
    req = 1; tick(); req = 0;
    for (int k = 0; k < 5; k++) begin
      check(bus() == NOPV, "R3 wait cke", bus(), NOPV);
      tick();
    end
    cke = 1; tick();
    check(bus() == wrv(ea), "R3 issue after cke", bus(), wrv(ea));
    repeat (TMRD) tick();

    // R5 request during window held
    set_cfg(12'h111); req = 1; tick(); req = 0;
    check(bus() == wrv(expect_addr()), "R5 first write", bus(), wrv(expect_addr()));
    set_cfg(12'hC3E); ea = expect_addr();
    req = 1; tick(); req = 0;
    for (int k = 2; k <= TMRD; k++) tick();
    check(bus() == NOPV, "R5 held nop", bus(), NOPV);
    tick();
    check(bus() == wrv(ea), "R5 held write", bus(), wrv(ea));
    repeat (TMRD) tick();

    // R7 DLL off write
    set_cfg(12'h001); req = 1; tick(); req = 0;
    repeat (LOCK_CYC + 5) tick();
    check(rok == 0, "R7 dll off", rok, 0);

    // R6 DLL on lockout
    set_cfg(12'h000); req = 1; tick(); req = 0;
    repeat (LOCK_CYC - 1) tick();
    check(rok == 0, "R6 before lockout end", rok, 0);
    tick();
    check(rok == 1, "R6 lockout end", rok, 1);

    // R8 self refresh
    sre = 1; tick(); sre = 0;
    check(rok == 0, "R8 in self refresh", rok, 0);
    repeat (10) tick();
    srx = 1; tick(); srx = 0;
    repeat (LOCK_CYC - 1) tick();
    check(rok == 0, "R8 before relock end", rok, 0);
    tick();
    check(rok == 1, "R8 relock end", rok, 1);

    // R7 DLL off drops read permission
    set_cfg(12'h001); req = 1; tick(); req = 0;
    check(rok == 0, "R7 drop", rok, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule